// File: doc/BRIEF.md
# Device Configuration Control Sequencer

This block steps a programmable device from power-up to user mode. It stays idle until all three supply-good inputs read high. It then runs three stages in fixed order. First it erases the configuration memory. Next it loads the configuration data. Last it runs a start-up phase that brings up the user application. When start-up ends it raises a done flag and holds it.

The sequencer shares an active-low, open-drain status line with other parties. It pulls the line low while it erases memory and while it reports an error. It reads the line's resolved level back through `init_in`. Any external agent that holds the line low after erasing finishes stalls the sequence before loading. Pulling the active-low program input low restarts the erase stage from any state. Losing any supply returns the block to idle.

During loading in serial daisy-chain mode, the block counts bitstream bits against a budget of `MAX_BITS`, which defaults to 4,294,967,264. One bit beyond the budget moves it into a latched error state. In JTAG-chain mode there is no budget.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is low and the block is idle.
- R2: The block leaves idle only when `pwr_core_ok`, `pwr_aux_ok` and `pwr_bank_ok` are all high. The erase stage (`mem_clear`) starts on the next clock edge. If any of the three is low at a clock edge, the block returns to idle and all its outputs go low.
- R3: `mem_clear` and `init_drive_low` are high together for the whole erase stage. The stage lasts `CLEAR_CYC` cycles, or ends at the edge where a `clear_done` pulse is sampled, whichever comes first.
- R4: After erasing, the block releases the status line and waits. `load_en` rises only at the edge after `init_in` is sampled high.
- R5: `load_en` stays high until `load_complete` is sampled. The start-up stage then begins.
- R6: `startup_en` is high for exactly `START_CYC` cycles. After that `done` goes high and stays high until a program request or a supply loss.
- R7: When `jtag_mode` is 0, every `bit_valid` sampled during loading counts as one bit. A bit sampled after `MAX_BITS` bits have already been counted moves the block to an error state. In that state `len_err` and `init_drive_low` stay high until `prog_n` is sampled low. Exactly `MAX_BITS` bits followed by `load_complete` is not an error.
- R8: When `jtag_mode` is 1, no number of bits raises `len_err`.
- R9: `prog_n` sampled low in any non-idle state puts the block in the erase stage at the next edge. The erase timer restarts from zero each cycle that `prog_n` stays low.
- R10: At most one of `mem_clear`, `load_en`, `startup_en` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_core_ok | input | 1 | Core supply above threshold |
| pwr_aux_ok | input | 1 | Auxiliary supply above threshold |
| pwr_bank_ok | input | 1 | Configuration bank supply above threshold |
| prog_n | input | 1 | Active-low program request |
| init_in | input | 1 | Resolved level of the shared status line |
| clear_done | input | 1 | Early end of memory erase |
| load_complete | input | 1 | End of configuration load |
| bit_valid | input | 1 | One bitstream bit passed in this cycle |
| jtag_mode | input | 1 | 1 = JTAG chain, so no length budget |
| init_drive_low | output | 1 | Pull the status line low |
| mem_clear | output | 1 | Erase stage active |
| load_en | output | 1 | Load stage active |
| startup_en | output | 1 | Start-up stage active |
| done | output | 1 | User mode reached |
| len_err | output | 1 | Bitstream length budget exceeded |

## Verification
The bench holds the status line low past the end of erasing. A design that ignores `init_in` would start loading too early. It feeds exactly the budget and then one bit more. An off-by-one counter would either fail a legal stream or let an over-long stream through. It also aborts from user mode, from the error state and in the middle of erasing, and ends erasing early with `clear_done`. A design that does not restart its erase timer, or that leaves the error state without a program request, would then show `mem_clear`, `done` or `len_err` in the wrong cycles. JTAG-mode streams longer than the budget, and a supply drop in the middle of loading, check that the budget is bypassed and that power loss takes priority.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_WAIT_LINE,
    ST_LOAD,
    ST_START,
    ST_USER,
    ST_FAULT
  } cfg_state_t;
endpackage

// File: rtl/cfg_hold_timer.sv
module cfg_hold_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int W = (LEN < 2) ? 1 : $clog2(LEN);

  logic [W-1:0] cnt;

  assign last = run && (cnt == W'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!last)  cnt <= cnt + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(LEN - 1));
endmodule

// File: rtl/cfg_bit_budget.sv
module cfg_bit_budget #(
  parameter longint unsigned MAX_BITS = 64'd4294967264
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_valid,
  output logic over
);
  localparam int BW = $clog2(MAX_BITS + 1);

  logic [BW-1:0] cnt;
  logic          at_max;

  assign at_max = (cnt == BW'(MAX_BITS));
  assign over   = run && bit_valid && at_max;

  always_ff @(posedge clk) begin
    if (rst || !run)              cnt <= '0;
    else if (bit_valid && !at_max) cnt <= cnt + 1'b1;
  end

  // R7
  budget_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= BW'(MAX_BITS));
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int              CLEAR_CYC = 64,
  parameter int              START_CYC = 8,
  parameter longint unsigned MAX_BITS  = 64'd4294967264
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_core_ok,
  input  logic pwr_aux_ok,
  input  logic pwr_bank_ok,
  input  logic prog_n,
  input  logic init_in,
  input  logic clear_done,
  input  logic load_complete,
  input  logic bit_valid,
  input  logic jtag_mode,
  output logic init_drive_low,
  output logic mem_clear,
  output logic load_en,
  output logic startup_en,
  output logic done,
  output logic len_err
);
  cfg_state_t state, nxt;
  logic pwr_all;
  logic erase_last, start_last, too_long;

  assign pwr_all = pwr_core_ok && pwr_aux_ok && pwr_bank_ok;

  cfg_hold_timer #(.LEN(CLEAR_CYC)) u_erase_tmr (
    .clk (clk),
    .rst (rst),
    .run (state == ST_ERASE && prog_n && pwr_all),
    .last(erase_last)
  );

  cfg_hold_timer #(.LEN(START_CYC)) u_start_tmr (
    .clk (clk),
    .rst (rst),
    .run (state == ST_START && prog_n && pwr_all),
    .last(start_last)
  );

  cfg_bit_budget #(.MAX_BITS(MAX_BITS)) u_budget (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_LOAD && !jtag_mode),
    .bit_valid(bit_valid),
    .over     (too_long)
  );

  always_comb begin
    nxt = state;
    if (!pwr_all)               nxt = ST_IDLE;
    else if (state == ST_IDLE)  nxt = ST_ERASE;
    else if (!prog_n)           nxt = ST_ERASE;
    else begin
      unique case (state)
        ST_ERASE:     if (clear_done || erase_last) nxt = ST_WAIT_LINE;
        ST_WAIT_LINE: if (init_in) nxt = ST_LOAD;
        ST_LOAD: begin
          if (too_long)           nxt = ST_FAULT;
          else if (load_complete) nxt = ST_START;
        end
        ST_START:     if (start_last) nxt = ST_USER;
        default:      nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      init_drive_low <= 1'b0;
      mem_clear      <= 1'b0;
      load_en        <= 1'b0;
      startup_en     <= 1'b0;
      done           <= 1'b0;
      len_err        <= 1'b0;
    end else begin
      state          <= nxt;
      init_drive_low <= (nxt == ST_ERASE) || (nxt == ST_FAULT);
      mem_clear      <= (nxt == ST_ERASE);
      load_en        <= (nxt == ST_LOAD);
      startup_en     <= (nxt == ST_START);
      done           <= (nxt == ST_USER);
      len_err        <= (nxt == ST_FAULT);
    end
  end

  // R3
  erase_pulls_line_chk: assert property (@(posedge clk) disable iff (rst)
    mem_clear |-> init_drive_low);
  // R4
  line_high_before_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(load_en) |-> $past(init_in));
  // R2
  power_loss_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_all |=> !(mem_clear || load_en || startup_en || done || len_err));
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done && prog_n && pwr_all |=> done);
  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    len_err && prog_n && pwr_all |=> len_err && init_drive_low);
  // R8
  jtag_no_budget_chk: assert property (@(posedge clk) disable iff (rst)
    jtag_mode && !len_err |=> !len_err);
  // R9
  prog_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n && pwr_all && state != ST_IDLE |=> mem_clear);
  // R10
  one_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_clear, load_en, startup_en, done}));
endmodule

// File: tb/cfg_seq_ctrl_test.sv
module cfg_seq_ctrl_test;
  localparam int CLR = 4;
  localparam int STC = 3;
  localparam int MAXB = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc = 0, pa = 0, pb = 0, prog_n = 1, ext_hold = 0;
  logic clear_done = 0, load_complete = 0, bit_valid = 0, jtag_mode = 0;
  logic init_drive_low, mem_clear, load_en, startup_en, done, len_err;
  logic init_line;

  assign init_line = !(init_drive_low || ext_hold);

  always #2 clk = ~clk;

  cfg_seq_ctrl #(.CLEAR_CYC(CLR), .START_CYC(STC), .MAX_BITS(MAXB)) uut (
    .clk(clk), .rst(rst), .pwr_core_ok(pc), .pwr_aux_ok(pa), .pwr_bank_ok(pb),
    .prog_n(prog_n), .init_in(init_line), .clear_done(clear_done),
    .load_complete(load_complete), .bit_valid(bit_valid), .jtag_mode(jtag_mode),
    .init_drive_low(init_drive_low), .mem_clear(mem_clear), .load_en(load_en),
    .startup_en(startup_en), .done(done), .len_err(len_err));

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // reference model: 0 idle,1 erase,2 wait,3 load,4 start,5 user,6 fault
  int ms = 0, mclr = 0, mst = 0, mbits = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin ms = 0; mclr = 0; mst = 0; mbits = 0; end
    else if (!(pc && pa && pb)) ms = 0;
    else if (ms == 0) begin ms = 1; mclr = 0; end
    else if (!prog_n) begin ms = 1; mclr = 0; end
    else begin
      case (ms)
        1: if (clear_done || mclr == CLR - 1) ms = 2; else mclr++;
        2: if (init_line) begin ms = 3; mbits = 0; end
        3: begin
          if (bit_valid && !jtag_mode) begin
            if (mbits == MAXB) ms = 6; else mbits++;
          end
          if (ms == 3 && load_complete) begin ms = 4; mst = 0; end
        end
        4: if (mst == STC - 1) ms = 5; else mst++;
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R10 mem_clear", mem_clear, ms == 1);
    chk("R3 init_drive_low", init_drive_low, ms == 1 || ms == 6);
    chk("R5 load_en", load_en, ms == 3);
    chk("R6 startup_en", startup_en, ms == 4);
    chk("R6 done", done, ms == 5);
    chk("R7 len_err", len_err, ms == 6);
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_bits(int n);
    for (int i = 0; i < n; i++) begin bit_valid = 1; step(); end
    bit_valid = 0;
  endtask

  initial begin
    step(3);
    rst = 0;
    step();
    chk("R1 outputs idle after reset", mem_clear | load_en | done | len_err | init_drive_low, 1'b0);
    pc = 1; pa = 1; step(3);
    chk("R2 partial power stays idle", mem_clear, 1'b0);
    pb = 1; step();
    chk("R2 erase starts on power good", mem_clear, 1'b1);
    ext_hold = 1;
    step(CLR);
    chk("R4 held line blocks load", load_en, 1'b0);
    step(3);
    chk("R4 still waiting on line", load_en, 1'b0);
    ext_hold = 0; step();
    step();
    chk("R4 load after line high", load_en, 1'b1);
    pulse_bits(MAXB);
    load_complete = 1; step(); load_complete = 0;
    chk("R5 exact budget accepted", startup_en, 1'b1);
    chk("R7 no error at exact budget", len_err, 1'b0);
    step(STC);
    chk("R6 done after start-up", done, 1'b1);
    step(5);
    chk("R6 done held", done, 1'b1);
    // abort from user mode, held low, then early clear_done
    prog_n = 0; step(3);
    chk("R9 held prog keeps erase", mem_clear, 1'b1);
    prog_n = 1; step(1);
    clear_done = 1; step(); clear_done = 0;
    chk("R3 early clear_done ends erase", mem_clear, 1'b0);
    step(); 
    chk("R4 load after free line", load_en, 1'b1);
    pulse_bits(MAXB + 1);
    chk("R7 overflow raises error", len_err, 1'b1);
    load_complete = 1; step(4); load_complete = 0;
    chk("R7 error sticky", len_err, 1'b1);
    prog_n = 0; step(); prog_n = 1;
    chk("R9 prog leaves error", mem_clear, 1'b1);
    step(CLR + 1);
    jtag_mode = 1;
    chk("R8 load in jtag mode", load_en, 1'b1);
    pulse_bits(MAXB + 6);
    chk("R8 no budget in jtag mode", len_err, 1'b0);
    pb = 0; step();
    chk("R2 supply loss idles", load_en | mem_clear, 1'b0);
    pb = 1; step(2);
    chk("R2 recovery restarts erase", mem_clear, 1'b1);
    rst = 1; step(2);
    chk("R1 reset idles", mem_clear, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule